// File: doc/BRIEF.md
# Address-Masked GPIO Register Port

This block is an eight-pin general-purpose I/O port behind a 32-bit APB-style register interface that decodes a 4 KB window. Each pin is an input or an output, chosen by a direction register. Output pins are driven from a data byte. Input pins are sampled through a two-flop synchronizer, and their levels flow into the same data byte, so software reads both kinds of pin through one register.

The data register appears at 256 word addresses, from offset 0x000 to 0x3FC. Address bits [9:2] form a per-bit mask. On a read, bits whose mask bit is 0 return 0. On a write, only the bits whose mask bit is 1 change. Software can therefore set or clear one pin without a read-modify-write sequence, and two agents that own different pins cannot overwrite each other's bits.

The port also holds the configuration bytes that a separate interrupt unit uses, plus an alternate-function select byte, and presents all of them on output ports. It returns the interrupt unit's raw status, and the raw status masked by the enable byte, through two read-only offsets. A write to the clear offset turns into a one-cycle clear pulse for that unit. The interrupt detection itself is outside this block.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset every stored byte is 0. That covers data, direction, the four interrupt configuration bytes and alternate-function select. All pins are therefore inputs (pin_oe = 0), and the direction register reads 0.
- R2: A read in the data range (paddr[11:10] = 0) returns the data byte ANDed with paddr[9:2] on prdata[7:0]. Bits whose mask bit is 0 read as 0.
- R3: A write in the data range replaces only the output-pin bits whose mask bit paddr[9:2] is 1, taking the values from pwdata[7:0]. Every other data bit keeps its value.
- R4: A data bit whose direction bit is 0 follows its input pin through a two-flop synchronizer. A pin change applied before clock edge k appears on data_o after edge k+2 and not earlier. CPU writes leave these bits unchanged.
- R5: Offset 0x400 holds the direction byte, with 1 meaning output. pin_oe equals the direction byte, and pin_o drives the data bit on output pins and 0 on input pins.
- R6: Offsets 0x404, 0x408, 0x40C and 0x410 hold the interrupt sense, both-edges, event and enable bytes. Offset 0x420 holds the alternate-function select byte. Each of these is read/write, keeps only pwdata[7:0], and appears on its own output port.
- R7: Offset 0x414 reads irq_raw_i. Offset 0x418 reads irq_raw_i ANDed with the enable byte.
- R8: A write to offset 0x41C drives pwdata[7:0] on irq_clr_o for exactly the one cycle after the write edge, and 0 at all other times. That offset reads 0.
- R9: Offset 0xFE0 reads 0x61.
- R10: Unmapped offsets read 0, and writes to them change no state. prdata[31:8] is always 0.
- R11: pready is always 1 and pslverr is always 0. A write takes effect at the rising edge that ends its access phase (psel and penable both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer ready, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| pin_i | input | 8 | Pin input levels (asynchronous) |
| pin_o | output | 8 | Pin output levels |
| pin_oe | output | 8 | Pin output enables |
| data_o | output | 8 | Current data byte |
| dir_o | output | 8 | Direction byte |
| afsel_o | output | 8 | Alternate-function select byte |
| irq_sense_o | output | 8 | Interrupt sense byte |
| irq_both_o | output | 8 | Interrupt both-edges byte |
| irq_event_o | output | 8 | Interrupt event byte |
| irq_enable_o | output | 8 | Interrupt enable byte |
| irq_raw_i | input | 8 | Raw interrupt status from the interrupt unit |
| irq_clr_o | output | 8 | One-cycle interrupt clear pulse |

## Verification
The checker watches these properties on every cycle:
- upper read bits stay zero, and masked-off data bits read zero;
- a data write leaves unmasked output bits untouched and loads masked output bits from the bus;
- the direction byte moves only on a write to its offset;
- a clear pulse appears only after a write to the clear offset;
- the handshake stays fixed.

Only the bench scenarios can show the other behaviours:
- the exact synchronizer latency;
- input bits resisting CPU writes;
- the identification value;
- status masking against a live enable byte;
- the reset values of all registers.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned NPINS  = 8;
  localparam int unsigned AW     = 12;
  localparam int unsigned DW     = 32;

  localparam logic [AW-1:0] OFS_DIR   = 12'h400;
  localparam logic [AW-1:0] OFS_SENSE = 12'h404;
  localparam logic [AW-1:0] OFS_BOTH  = 12'h408;
  localparam logic [AW-1:0] OFS_EVENT = 12'h40C;
  localparam logic [AW-1:0] OFS_IEN   = 12'h410;
  localparam logic [AW-1:0] OFS_RAW   = 12'h414;
  localparam logic [AW-1:0] OFS_MSK   = 12'h418;
  localparam logic [AW-1:0] OFS_CLR   = 12'h41C;
  localparam logic [AW-1:0] OFS_AFSEL = 12'h420;
  localparam logic [AW-1:0] OFS_ID0   = 12'hFE0;
  localparam logic [7:0]    ID0_VALUE = 8'h61;

  localparam int unsigned NCFG = 6;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_DIR, SEL_SENSE, SEL_BOTH, SEL_EVENT,
    SEL_IEN, SEL_RAW, SEL_MSK, SEL_CLR, SEL_AFSEL, SEL_ID0
  } reg_sel_e;

  localparam reg_sel_e CFG_SEL [NCFG] = '{SEL_DIR, SEL_SENSE, SEL_BOTH,
                                          SEL_EVENT, SEL_IEN, SEL_AFSEL};
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_mask_pkg::*;
#(
  parameter int unsigned W = NPINS
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel,
  output logic [W-1:0]  mask
);
  localparam int unsigned MLO = 2;

  logic unused_addr;
  assign unused_addr = ^addr[MLO-1:0];

  assign mask = addr[MLO+W-1:MLO];

  always_comb begin
    sel = SEL_NONE;
    if (addr[AW-1:MLO+W] == '0) begin
      sel = SEL_DATA;
    end else begin
      unique case ({addr[AW-1:MLO], 2'b00})
        OFS_DIR:   sel = SEL_DIR;
        OFS_SENSE: sel = SEL_SENSE;
        OFS_BOTH:  sel = SEL_BOTH;
        OFS_EVENT: sel = SEL_EVENT;
        OFS_IEN:   sel = SEL_IEN;
        OFS_RAW:   sel = SEL_RAW;
        OFS_MSK:   sel = SEL_MSK;
        OFS_CLR:   sel = SEL_CLR;
        OFS_AFSEL: sel = SEL_AFSEL;
        OFS_ID0:   sel = SEL_ID0;
        default:   sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_byte_reg.sv
module gpio_byte_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = q;
    if (we) d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] data_q
);
  logic [W-1:0] merged;
  logic [W-1:0] data_d;

  always_comb begin
    merged = data_q;
    if (wr_en) merged = (wdata & mask) | (data_q & ~mask);
    data_d = (merged & dir) | (pin_sync & ~dir);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [DW-1:0]    pwdata,
  output logic [DW-1:0]    prdata,
  output logic             pready,
  output logic             pslverr,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_o,
  output logic [NPINS-1:0] pin_oe,
  output logic [NPINS-1:0] data_o,
  output logic [NPINS-1:0] dir_o,
  output logic [NPINS-1:0] afsel_o,
  output logic [NPINS-1:0] irq_sense_o,
  output logic [NPINS-1:0] irq_both_o,
  output logic [NPINS-1:0] irq_event_o,
  output logic [NPINS-1:0] irq_enable_o,
  input  logic [NPINS-1:0] irq_raw_i,
  output logic [NPINS-1:0] irq_clr_o
);
  localparam int unsigned PADW = DW - NPINS;

  reg_sel_e         sel;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] cfg_q [NCFG];
  logic [NCFG-1:0]  cfg_we;
  logic             wr_acc;
  logic [NPINS-1:0] clr_d, clr_q;
  logic [NPINS-1:0] rd_byte;
  logic             unused_wdata;

  assign unused_wdata = ^pwdata[DW-1:NPINS];
  assign wr_acc  = psel & penable & pwrite;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  gpio_addr_decode #(.W(NPINS)) u_dec (
    .addr (paddr),
    .sel  (sel),
    .mask (mask)
  );

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    assign cfg_we[i] = wr_acc && (sel == CFG_SEL[i]);
    gpio_byte_reg #(.W(NPINS)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we[i]),
      .wdata (pwdata[NPINS-1:0]),
      .q     (cfg_q[i])
    );
  end

  assign dir_o        = cfg_q[0];
  assign irq_sense_o  = cfg_q[1];
  assign irq_both_o   = cfg_q[2];
  assign irq_event_o  = cfg_q[3];
  assign irq_enable_o = cfg_q[4];
  assign afsel_o      = cfg_q[5];

  gpio_data_reg #(.W(NPINS)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_acc && (sel == SEL_DATA)),
    .mask     (mask),
    .wdata    (pwdata[NPINS-1:0]),
    .dir      (dir_o),
    .pin_sync (pin_sync),
    .data_q   (data_o)
  );

  assign pin_oe = dir_o;
  assign pin_o  = data_o & dir_o;

  always_comb begin
    clr_d = '0;
    if (wr_acc && (sel == SEL_CLR)) clr_d = pwdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= '0;
    else        clr_q <= clr_d;
  end

  assign irq_clr_o = clr_q;

  always_comb begin
    unique case (sel)
      SEL_DATA:  rd_byte = data_o & mask;
      SEL_DIR:   rd_byte = dir_o;
      SEL_SENSE: rd_byte = irq_sense_o;
      SEL_BOTH:  rd_byte = irq_both_o;
      SEL_EVENT: rd_byte = irq_event_o;
      SEL_IEN:   rd_byte = irq_enable_o;
      SEL_RAW:   rd_byte = irq_raw_i;
      SEL_MSK:   rd_byte = irq_raw_i & irq_enable_o;
      SEL_AFSEL: rd_byte = afsel_o;
      SEL_ID0:   rd_byte = ID0_VALUE;
      default:   rd_byte = '0;
    endcase
  end

  assign prdata = {{PADW{1'b0}}, rd_byte};
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] pwdata,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        pslverr,
  input logic [7:0]  data_o,
  input logic [7:0]  dir_o,
  input logic [7:0]  irq_clr_o
);
  logic acc, data_wr, data_rd, dir_wr, clr_wr;
  assign acc     = psel & penable;
  assign data_wr = acc & pwrite & (paddr[11:10] == 2'b00);
  assign data_rd = acc & !pwrite & (paddr[11:10] == 2'b00);
  assign dir_wr  = acc & pwrite & (paddr == 12'h400);
  assign clr_wr  = acc & pwrite & (paddr == 12'h41C);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    psel |-> prdata[31:8] == 24'h0); // R10

  AST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> (prdata[7:0] & ~paddr[9:2]) == 8'h00); // R2

  AST_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((data_o & $past(dir_o & ~paddr[9:2])) ==
                 ($past(data_o) & $past(dir_o & ~paddr[9:2])))); // R3

  AST_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((data_o & $past(dir_o & paddr[9:2])) ==
                 ($past(pwdata[7:0]) & $past(dir_o & paddr[9:2])))); // R3

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_o)); // R5

  AST_CLR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_o != 8'h00) |-> $past(clr_wr)); // R8

  AST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R11
endmodule

bind gpio_mask_port gpio_mask_port_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .prdata    (prdata),
  .pready    (pready),
  .pslverr   (pslverr),
  .data_o    (data_o),
  .dir_o     (dir_o),
  .irq_clr_o (irq_clr_o)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  pin_i = 8'h00;
  logic [7:0]  pin_o, pin_oe, data_o, dir_o, afsel_o;
  logic [7:0]  irq_sense_o, irq_both_o, irq_event_o, irq_enable_o, irq_clr_o;
  logic [7:0]  irq_raw_i = 8'h5A;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_mask_port u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .data_o(data_o), .dir_o(dir_o), .afsel_o(afsel_o),
    .irq_sense_o(irq_sense_o), .irq_both_o(irq_both_o),
    .irq_event_o(irq_event_o), .irq_enable_o(irq_enable_o),
    .irq_raw_i(irq_raw_i), .irq_clr_o(irq_clr_o)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h400, 32'h0000_00FF, 8'h00, 4'd5},  // R5 all outputs
    '{1'b0, 12'h400, 32'h0,         8'hFF, 4'd5},  // R5
    '{1'b1, 12'h3FC, 32'h0000_00A5, 8'h00, 4'd3},  // R3 full mask
    '{1'b0, 12'h3FC, 32'h0,         8'hA5, 4'd2},  // R2
    '{1'b0, 12'h03C, 32'h0,         8'h05, 4'd2},  // R2 mask 0x0F
    '{1'b1, 12'h004, 32'h0000_0000, 8'h00, 4'd3},  // R3 clear bit 0
    '{1'b0, 12'h3FC, 32'h0,         8'hA4, 4'd3},
    '{1'b1, 12'h300, 32'h0000_00FF, 8'h00, 4'd3},  // R3 set bits 7:6
    '{1'b0, 12'h3FC, 32'h0,         8'hE4, 4'd3},
    '{1'b0, 12'h000, 32'h0,         8'h00, 4'd2},  // R2 empty mask
    '{1'b1, 12'h000, 32'h0000_00FF, 8'h00, 4'd3},  // R3 empty mask write
    '{1'b0, 12'h3FC, 32'h0,         8'hE4, 4'd3},
    '{1'b1, 12'h404, 32'hFFFF_FF12, 8'h00, 4'd6},  // R6
    '{1'b0, 12'h404, 32'h0,         8'h12, 4'd6},
    '{1'b1, 12'h408, 32'h0000_0034, 8'h00, 4'd6},
    '{1'b0, 12'h408, 32'h0,         8'h34, 4'd6},
    '{1'b1, 12'h40C, 32'h0000_0056, 8'h00, 4'd6},
    '{1'b0, 12'h40C, 32'h0,         8'h56, 4'd6},
    '{1'b1, 12'h410, 32'h0000_00F0, 8'h00, 4'd6},
    '{1'b0, 12'h410, 32'h0,         8'hF0, 4'd6},
    '{1'b1, 12'h420, 32'h0000_003C, 8'h00, 4'd6},
    '{1'b0, 12'h420, 32'h0,         8'h3C, 4'd6},
    '{1'b0, 12'h414, 32'h0,         8'h5A, 4'd7},  // R7 raw
    '{1'b0, 12'h418, 32'h0,         8'h50, 4'd7},  // R7 masked
    '{1'b0, 12'hFE0, 32'h0,         8'h61, 4'd9},  // R9
    '{1'b1, 12'h800, 32'h0000_00FF, 8'h00, 4'd10}, // R10 unmapped write
    '{1'b0, 12'h800, 32'h0,         8'h00, 4'd10}  // R10 unmapped read
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R11: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
    apb_read(12'h400, rd);  check("R1 dir read", rd, 32'h0);
    apb_read(12'h420, rd);  check("R1 afsel read", rd, 32'h0);
    apb_read(12'h3FC, rd);  check("R1 data read", rd, 32'h0);
    check("R11 handshake", {30'h0, pready, pslverr}, 32'h2);

    foreach (VECS[i]) begin
      if (VECS[i].wr) begin
        apb_write(VECS[i].addr, VECS[i].wdata);
      end else begin
        apb_read(VECS[i].addr, rd);
        check($sformatf("R%0d vec %0d", VECS[i].req, i), rd, {24'h0, VECS[i].exp});
      end
    end

    // R10 unmapped write left every byte unchanged
    check("R10 data after unmapped write", {24'h0, data_o}, 32'hE4);
    check("R10 afsel after unmapped write", {24'h0, afsel_o}, 32'h3C);
    check("R6 cfg ports", {irq_sense_o, irq_both_o, irq_event_o, irq_enable_o},
          32'h1234_56F0);

    // R8 clear pulse
    apb_write(12'h41C, 32'h0000_0081);
    check("R8 pulse", {24'h0, irq_clr_o}, 32'h81);
    @(negedge clk);
    check("R8 pulse ends", {24'h0, irq_clr_o}, 32'h0);
    apb_read(12'h41C, rd);  check("R8 read zero", rd, 32'h0);

    // R4/R5 mixed direction
    apb_write(12'h400, 32'h0000_000F);
    @(negedge clk);
    pin_i = 8'hA0;
    @(negedge clk);
    @(negedge clk);
    check("R4 not yet after two edges", {24'h0, data_o[7:4], 4'h0}, 32'h0);
    @(negedge clk);
    check("R4 visible after three edges", {24'h0, data_o}, 32'hA4);
    apb_write(12'h3FC, 32'h0000_005F);
    apb_read(12'h3FC, rd);  check("R4 input bits resist write", rd, 32'hAF);
    check("R5 pin_oe", {24'h0, pin_oe}, 32'h0F);
    check("R5 pin_o", {24'h0, pin_o}, 32'h0F);
    pin_i = 8'h50;
    repeat (4) @(negedge clk);
    apb_read(12'h3C0, rd);  check("R4 follow new pins, mask F0", rd, 32'h50);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule